// File: doc/BRIEF.md
# Received-Symbol Histogram Counter

This block builds a histogram of the 10-bit symbols arriving on one serial video channel. Every accepted symbol is used directly as an index into a table of 16-bit counters, and that counter is incremented. The counters sit in two block-RAM banks. Accepted words alternate between the banks: the even-numbered word goes to bank 0 and the odd-numbered word to bank 1. Each bank therefore sees at most one update every second pixel clock. The stream runs at one symbol per clock and never stalls. Software adds the two banks to get the full histogram.

A host in the separate system clock domain controls the block. A run level enables counting. A clear pulse zeroes both banks with a hardware address walk, and a busy flag reports when the walk has finished. A read port returns one counter from a chosen bank while counting is stopped. The usual flow is: clear, wait for busy to drop, raise run for the measurement window, drop run, then read out both banks.

Top module: `histCounter`

## Requirements
- R1: After reset, hostBusy and hostRdValid are both 0.
- R2: A symbol is accepted when symValid is high in a pixel-clock cycle while run is in effect and no clear is running. Each accepted symbol adds one to the counter whose index equals the symbol value. Accepted words alternate between banks. The first accepted word after reset or after a clear goes to bank 0, the next to bank 1, and so on.
- R3: Counters are 16 bits wide and saturate: a counter at 0xFFFF stays at 0xFFFF.
- R4: Symbols may arrive on every pixel clock, including long runs of one value. No increment is lost, because a read that meets a write to the same counter takes the written value.
- R5: While hostRun is low, or while symValid is low, the counters do not change.
- R6: A hostClear pulse while hostBusy is low sets hostBusy on the next system clock. It also writes zero to every counter in both banks and restarts the bank alternation at bank 0. hostBusy falls after the walk completes.
- R7: hostRdEn, while hostRun and hostBusy are low, returns on the next system clock edge the counter at hostRdAddr. hostRdBank selects the bank (0 = even words, 1 = odd words). The value appears on hostRdData with hostRdValid high.
- R8: hostRdEn while hostRun or hostBusy is high is ignored, and hostRdValid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System (host) clock |
| pixClk | input | 1 | Pixel clock of the symbol stream |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| hostRun | input | 1 | Counting enable level (system domain) |
| hostClear | input | 1 | One-cycle pulse that starts a clear walk |
| hostBusy | output | 1 | High while a clear is pending or running |
| hostRdEn | input | 1 | Read request for one counter |
| hostRdBank | input | 1 | Bank to read: 0 even words, 1 odd words |
| hostRdAddr | input | 10 | Counter index to read |
| hostRdData | output | 16 | Counter value returned |
| hostRdValid | output | 1 | hostRdData holds a fresh result |
| symValid | input | 1 | Symbol present this pixel clock |
| symIn | input | 10 | Received symbol |

## Verification
The assertions assume the host keeps hostRun and hostClear stable long enough to cross into the pixel domain. They also assume host reads are issued only after the pipeline has drained following a stop, so the system-side RAM port never reads a counter while it is being written. The stimulus follows these rules. After changing hostRun it waits several system cycles before feeding symbols or reading, and it polls hostBusy until it falls after each clear. Within those limits it drives back-to-back words, gaps in symValid, long runs of a single value, and symbols presented while stopped.

// File: rtl/histPkg.sv
`timescale 1ns/1ps
package histPkg;
  // Strobes from the control unit to the datapath, pixel domain.
  typedef struct packed {
    logic issue;    // accept the current symbol and start its read
    logic bankOdd;  // bank that receives this word
    logic clr;      // clear walk active; write zero at clrAddr
  } ctrlStrobeT;
endpackage

// File: rtl/histCtrl.sv
`timescale 1ns/1ps
module histCtrl
  import histPkg::*;
#(
  parameter int SYM_W = 10
) (
  input  logic             sysClk,
  input  logic             pixClk,
  input  logic             rstN,
  input  logic             hostRun,
  input  logic             hostClear,
  input  logic             hostRdEn,
  input  logic             symValid,
  output logic             hostBusy,
  output logic             rdGo,
  output ctrlStrobeT       strobe,
  output logic [SYM_W-1:0] clrAddr
);
  localparam logic [SYM_W-1:0] ADDR_LAST = {SYM_W{1'b1}};

  // system domain: clear request toggle and acknowledge synchronizer
  logic       reqTog;
  logic [1:0] ackSync;
  logic       ackTog;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      reqTog  <= 1'b0;
      ackSync <= 2'b00;
    end else begin
      ackSync <= {ackSync[0], ackTog};
      if (hostClear && !hostBusy) reqTog <= ~reqTog;
    end
  end

  assign hostBusy = reqTog ^ ackSync[1];
  assign rdGo     = hostRdEn && !hostRun && !hostBusy;

  // pixel domain: run sync, clear walk, bank parity
  logic [1:0] runSync;
  logic [2:0] reqSync;
  logic       clrActive;
  logic       parity;
  logic       issue;

  assign issue = symValid && runSync[1] && !clrActive;

  always_ff @(posedge pixClk or negedge rstN) begin
    if (!rstN) begin
      runSync   <= '0;
      reqSync   <= '0;
      clrActive <= 1'b0;
      clrAddr   <= '0;
      ackTog    <= 1'b0;
      parity    <= 1'b0;
    end else begin
      runSync <= {runSync[0], hostRun};
      reqSync <= {reqSync[1:0], reqTog};
      if (issue) parity <= ~parity;
      if (clrActive) begin
        clrAddr <= clrAddr + 1'b1;
        if (clrAddr == ADDR_LAST) begin
          clrActive <= 1'b0;
          ackTog    <= ~ackTog;
          parity    <= 1'b0;
        end
      end else if (reqSync[2] ^ reqSync[1]) begin
        clrActive <= 1'b1;
        clrAddr   <= '0;
      end
    end
  end

  always_comb begin
    strobe.issue   = issue;
    strobe.bankOdd = parity;
    strobe.clr     = clrActive;
  end
endmodule

// File: rtl/histDatapath.sv
`timescale 1ns/1ps
module histDatapath
  import histPkg::*;
#(
  parameter int SYM_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             pixClk,
  input  logic             sysClk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [SYM_W-1:0] clrAddr,
  input  logic [SYM_W-1:0] symIn,
  input  logic             rdGo,
  input  logic             rdBank,
  input  logic [SYM_W-1:0] rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid
);
  localparam int             DEPTH   = 1 << SYM_W;
  localparam int             BANKS   = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // stage 1: RAM output available
  logic             s1Valid, s1Odd;
  logic [SYM_W-1:0] s1Idx;
  // stage 2: pending increment write
  logic             wrValid, wrOdd;
  logic [SYM_W-1:0] wrIdx;
  logic [CNT_W-1:0] wrData;

  logic [BANKS-1:0][CNT_W-1:0] bankQ, fwdVal, hostQ;
  logic [BANKS-1:0]            fwdHit;
  logic [CNT_W-1:0]            oldCnt;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] rdQ, hQ, fVal;
    logic             fHit;
    logic             re, we, incWe;
    logic [SYM_W-1:0] wAddr;
    logic [CNT_W-1:0] wVal;

    assign re    = strobe.issue && (strobe.bankOdd == 1'(b));
    assign incWe = wrValid && (wrOdd == 1'(b));
    assign we    = strobe.clr || incWe;
    assign wAddr = strobe.clr ? clrAddr : wrIdx;
    assign wVal  = strobe.clr ? '0 : wrData;

    always_ff @(posedge pixClk) begin
      if (we) mem[wAddr] <= wVal;
      if (re) rdQ <= mem[symIn];
    end

    // a read sampled at the same edge as a write to that counter sees stale data
    always_ff @(posedge pixClk or negedge rstN) begin
      if (!rstN) begin
        fHit <= 1'b0;
        fVal <= '0;
      end else if (re) begin
        fHit <= incWe && (wrIdx == symIn);
        fVal <= wrData;
      end
    end

    always_ff @(posedge sysClk) begin
      if (rdGo && (rdBank == 1'(b))) hQ <= mem[rdAddr];
    end

    assign bankQ[b]  = rdQ;
    assign fwdVal[b] = fVal;
    assign fwdHit[b] = fHit;
    assign hostQ[b]  = hQ;
  end

  assign oldCnt = fwdHit[s1Odd] ? fwdVal[s1Odd] : bankQ[s1Odd];

  always_ff @(posedge pixClk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Odd   <= 1'b0;
      s1Idx   <= '0;
      wrValid <= 1'b0;
      wrOdd   <= 1'b0;
      wrIdx   <= '0;
      wrData  <= '0;
    end else begin
      s1Valid <= strobe.issue && !strobe.clr;
      s1Odd   <= strobe.bankOdd;
      s1Idx   <= symIn;
      wrValid <= s1Valid && !strobe.clr;
      wrOdd   <= s1Odd;
      wrIdx   <= s1Idx;
      wrData  <= (oldCnt == CNT_MAX) ? oldCnt : oldCnt + 1'b1;
    end
  end

  logic rdBankQ;
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdBankQ <= 1'b0;
    end else begin
      rdValid <= rdGo;
      if (rdGo) rdBankQ <= rdBank;
    end
  end

  assign rdData = hostQ[rdBankQ];
endmodule

// File: rtl/histCounter.sv
`timescale 1ns/1ps
module histCounter
  import histPkg::*;
#(
  parameter int SYM_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             sysClk,
  input  logic             pixClk,
  input  logic             rstN,
  input  logic             hostRun,
  input  logic             hostClear,
  output logic             hostBusy,
  input  logic             hostRdEn,
  input  logic             hostRdBank,
  input  logic [SYM_W-1:0] hostRdAddr,
  output logic [CNT_W-1:0] hostRdData,
  output logic             hostRdValid,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symIn
);
  ctrlStrobeT       strobe;
  logic [SYM_W-1:0] clrAddr;
  logic             rdGo;

  histCtrl #(.SYM_W(SYM_W)) u_ctrl (
    .sysClk(sysClk), .pixClk(pixClk), .rstN(rstN),
    .hostRun(hostRun), .hostClear(hostClear), .hostRdEn(hostRdEn),
    .symValid(symValid), .hostBusy(hostBusy), .rdGo(rdGo),
    .strobe(strobe), .clrAddr(clrAddr)
  );

  histDatapath #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_dp (
    .pixClk(pixClk), .sysClk(sysClk), .rstN(rstN),
    .strobe(strobe), .clrAddr(clrAddr), .symIn(symIn),
    .rdGo(rdGo), .rdBank(hostRdBank), .rdAddr(hostRdAddr),
    .rdData(hostRdData), .rdValid(hostRdValid)
  );
endmodule

// File: rtl/histChk.sv
`timescale 1ns/1ps
module histChk
  import histPkg::*;
#(
  parameter int SYM_W = 10
) (
  input logic             sysClk,
  input logic             pixClk,
  input logic             rstN,
  input logic             hostRun,
  input logic             hostClear,
  input logic             hostBusy,
  input logic             hostRdEn,
  input logic             hostRdValid,
  input logic             symValid,
  input ctrlStrobeT       strobe,
  input logic [SYM_W-1:0] clrAddr
);
  // R2: consecutive accepted words land in opposite banks
  p_bank_alternate_r2: assert property (@(posedge pixClk) disable iff (!rstN)
    (strobe.issue && $past(strobe.issue)) |-> (strobe.bankOdd != $past(strobe.bankOdd)));

  // R5: nothing is accepted without a valid symbol
  p_issue_needs_valid_r5: assert property (@(posedge pixClk) disable iff (!rstN)
    strobe.issue |-> symValid);

  // R6: the clear walk excludes counting and steps one address per clock
  p_clr_blocks_issue_r6: assert property (@(posedge pixClk) disable iff (!rstN)
    strobe.clr |-> !strobe.issue);

  p_clr_addr_step_r6: assert property (@(posedge pixClk) disable iff (!rstN)
    (strobe.clr && $past(strobe.clr)) |-> (clrAddr == $past(clrAddr) + 1'b1));

  p_busy_rises_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    (hostClear && !hostBusy) |=> hostBusy);

  // R7: a result only follows a permitted request
  p_valid_after_req_r7: assert property (@(posedge sysClk) disable iff (!rstN)
    hostRdValid |-> $past(hostRdEn && !hostRun && !hostBusy));

  // R8: reads while running or clearing are dropped
  p_rd_blocked_r8: assert property (@(posedge sysClk) disable iff (!rstN)
    (hostRdEn && (hostRun || hostBusy)) |=> !hostRdValid);
endmodule

bind histCounter histChk #(.SYM_W(SYM_W)) u_chk (
  .sysClk(sysClk), .pixClk(pixClk), .rstN(rstN),
  .hostRun(hostRun), .hostClear(hostClear), .hostBusy(hostBusy),
  .hostRdEn(hostRdEn), .hostRdValid(hostRdValid), .symValid(symValid),
  .strobe(strobe), .clrAddr(clrAddr)
);

// File: tb/sim_histCounter.sv
`timescale 1ns/1ps
module sim_histCounter;
  localparam int NSYM = 1024;
  localparam int CMAX = 65535;

  logic        sysClk = 0, pixClk = 0, rstN = 0;
  logic        hostRun = 0, hostClear = 0, hostRdEn = 0, hostRdBank = 0;
  logic [9:0]  hostRdAddr = '0;
  logic        symValid = 0;
  logic [9:0]  symIn = '0;
  logic        hostBusy, hostRdValid;
  logic [15:0] hostRdData;

  always #4 sysClk = ~sysClk;   // 125 MHz
  always #2 pixClk = ~pixClk;   // pixel clock

  histCounter u0 (
    .sysClk(sysClk), .pixClk(pixClk), .rstN(rstN),
    .hostRun(hostRun), .hostClear(hostClear), .hostBusy(hostBusy),
    .hostRdEn(hostRdEn), .hostRdBank(hostRdBank), .hostRdAddr(hostRdAddr),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid),
    .symValid(symValid), .symIn(symIn)
  );

  int checks = 0, fails = 0;
  int refC [2][NSYM];
  bit par = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendWord(int s, bit v);
    @(negedge pixClk);
    symValid = v;
    symIn    = 10'(s);
    if (v) begin
      if (refC[par][s] < CMAX) refC[par][s]++;
      par = ~par;
    end
  endtask

  task automatic idleSym();
    @(negedge pixClk);
    symValid = 0;
  endtask

  task automatic runOn();
    @(negedge sysClk) hostRun = 1;
    repeat (6) @(negedge sysClk);
  endtask

  task automatic runOff();
    @(negedge sysClk) hostRun = 0;
    repeat (8) @(negedge sysClk);
  endtask

  task automatic clearAll();
    @(negedge sysClk) hostClear = 1;
    @(negedge sysClk) hostClear = 0;
    check("R6 busy after clear", int'(hostBusy), 1);
    for (int i = 0; i < 4000 && hostBusy; i++) @(negedge sysClk);
    check("R6 busy drops", int'(hostBusy), 0);
    foreach (refC[b, a]) refC[b][a] = 0;
    par = 0;
  endtask

  task automatic readCnt(bit b, int a, output int v);
    @(negedge sysClk);
    hostRdEn = 1; hostRdBank = b; hostRdAddr = 10'(a);
    @(negedge sysClk);
    hostRdEn = 0;
    if (!hostRdValid) begin
      checks++; fails++;
      $display("FAIL R7 read valid actual=0 expected=1");
    end
    v = int'(hostRdData);
  endtask

  task automatic compareAll(string tag);
    int v;
    int bad = 0;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < NSYM; a++) begin
        readCnt(b[0], a, v);
        if (v != refC[b][a]) begin
          bad++;
          if (bad < 6)
            $display("FAIL %s bank=%0d idx=%0d actual=%0d expected=%0d", tag, b, a, v, refC[b][a]);
        end
      end
    checks++;
    if (bad != 0) fails++;
  endtask

  // R1
  task automatic tReset();
    check("R1 busy at reset", int'(hostBusy), 0);
    check("R1 valid at reset", int'(hostRdValid), 0);
  endtask

  // R6 and R7: cleared table reads back as zero
  task automatic tClear();
    clearAll();
    compareAll("R6 cleared table R7");
  endtask

  // R2, R4: back-to-back repeats and index boundaries
  task automatic tDirected();
    int v;
    runOn();
    for (int i = 0; i < 5; i++) sendWord(3, 1);
    sendWord(0, 1);
    sendWord(1023, 1);
    sendWord(1023, 1);
    for (int i = 0; i < 200; i++) sendWord(77, 1);
    idleSym();
    runOff();
    readCnt(0, 3, v); check("R2 even bank idx 3", v, 3);
    readCnt(1, 3, v); check("R2 odd bank idx 3", v, 2);
    readCnt(1, 0, v); check("R2 idx 0 in odd bank", v, 1);
    readCnt(0, 1023, v); check("R2 idx 1023 even", v, 1);
    readCnt(1, 1023, v); check("R2 idx 1023 odd", v, 1);
    readCnt(0, 77, v); check("R4 repeats even", v, 100);
    readCnt(1, 77, v); check("R4 repeats odd", v, 100);
  endtask

  // R5: stopped or invalid symbols do nothing
  task automatic tIgnored();
    int v;
    for (int i = 0; i < 10; i++) begin
      @(negedge pixClk); symValid = 1; symIn = 10'd9;
    end
    idleSym();
    repeat (4) @(negedge sysClk);
    readCnt(0, 9, v); check("R5 stopped even", v, 0);
    readCnt(1, 9, v); check("R5 stopped odd", v, 0);
    runOn();
    for (int i = 0; i < 10; i++) sendWord(9, 0);
    runOff();
    readCnt(0, 9, v); check("R5 invalid even", v, 0);
    readCnt(1, 9, v); check("R5 invalid odd", v, 0);
  endtask

  // R2, R4, R7: random stream with gaps and bursts
  task automatic tRandom();
    int last = 0;
    clearAll();
    runOn();
    for (int i = 0; i < 4000; i++) begin
      int s = ((i % 9) < 3) ? last : int'($urandom_range(0, NSYM - 1));
      bit v = ($urandom_range(0, 5) != 0);
      sendWord(s, v);
      last = s;
    end
    idleSym();
    runOff();
    compareAll("R2 R4 random table");
  endtask

  // R8: reads while running or while clearing are dropped
  task automatic tBlockedRead();
    runOn();
    @(negedge sysClk); hostRdEn = 1; hostRdAddr = 10'd5;
    @(negedge sysClk); hostRdEn = 0;
    check("R8 read while running", int'(hostRdValid), 0);
    runOff();
    @(negedge sysClk) hostClear = 1;
    @(negedge sysClk) hostClear = 0; hostRdEn = 1;
    @(negedge sysClk) hostRdEn = 0;
    check("R8 read while busy", int'(hostRdValid), 0);
    for (int i = 0; i < 4000 && hostBusy; i++) @(negedge sysClk);
    foreach (refC[b, a]) refC[b][a] = 0;
    par = 0;
  endtask

  // R6: clear restarts alternation at bank 0
  task automatic tParityRestart();
    int v;
    runOn();
    sendWord(4, 1); sendWord(4, 1); sendWord(4, 1);
    idleSym();
    runOff();
    clearAll();
    runOn();
    sendWord(4, 1);
    idleSym();
    runOff();
    readCnt(0, 4, v); check("R6 first word after clear even", v, 1);
    readCnt(1, 4, v); check("R6 odd bank empty", v, 0);
  endtask

  // R3: saturation at 0xFFFF
  task automatic tSaturate();
    int v;
    clearAll();
    runOn();
    for (int i = 0; i < 131090; i++) sendWord(7, 1);
    idleSym();
    runOff();
    readCnt(0, 7, v); check("R3 even saturated", v, CMAX);
    readCnt(1, 7, v); check("R3 odd saturated", v, CMAX);
    readCnt(0, 6, v); check("R3 neighbour untouched", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge sysClk);
    tReset();
    rstN = 1;
    repeat (3) @(negedge sysClk);
    tClear();
    tDirected();
    tIgnored();
    tRandom();
    tBlockedRead();
    tParityRestart();
    tSaturate();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule